// File: doc/BRIEF.md
# I2C Single-Master Byte Engine

This block is the bit-level core of an I2C master for a bus that has only one master. A host issues four kinds of commands: start condition, write one byte, read one byte and stop condition. The engine turns each command into SCL and SDA waveforms. Both lines are modelled as open-drain: the pad value is tied low, and the engine pulls a line down by asserting its output-enable. An external pull-up lifts a line whenever its enable is off.

Each command is offered with `cmd_valid` and is taken only while `busy` is low. When the command is complete, `done` pulses for one cycle. On a write, the host chooses per byte whether bits leave MSB-first or LSB-first, and it gets back an acknowledge status. On a read, the host marks the final byte of a burst, and that mark decides whether the master acknowledges on the ninth clock. All timing comes from one quarter-bit unit of `QUARTER_CLKS` system clocks. Every command except stop leaves SCL pulled low, so the next command can move SDA without creating a false start or stop.

Top module: `i2c_byte_engine`

## Requirements
- R1: `scl_o` and `sda_o` are always 0. A line is pulled low only while its output-enable is 1, and is released while it is 0.
- R2: While reset is held and after it is released, `scl_oe`, `sda_oe`, `busy` and `done` are 0.
- R3: In a byte transfer, SCL is released for exactly 2*QUARTER_CLKS clocks per bit. Consecutive SCL rising edges are 4*QUARTER_CLKS clocks apart.
- R4: Start, write and read commands end with SCL pulled low. During write and read commands, SDA never changes while SCL is released.
- R5: Start (`cmd_op`=0) releases SDA and then SCL, and pulls SDA low while SCL is high. This also works as a repeated start when SCL was left low.
- R6: Stop (`cmd_op`=3) pulls SDA low with SCL low, releases SCL, and then releases SDA while SCL is high. Both lines are released afterwards.
- R7: Write (`cmd_op`=1) puts the 8 bits of `cmd_wdata` on SDA. The order is MSB-first when `cmd_lsb_first`=0 and LSB-first when it is 1. SDA is released on the ninth clock.
- R8: After a write, `rsp_status` is 8'h00 if SDA was low at the ninth clock (acknowledge) and 8'h01 if it was high. Other commands report 8'h00.
- R9: Read (`cmd_op`=2) releases SDA for 8 clocks, samples SDA while SCL is high, and returns the bits MSB-first on `rsp_data`.
- R10: On the ninth clock of a read, SDA is released (not-acknowledge) when `cmd_last`=1 and pulled low (acknowledge) when `cmd_last`=0.
- R11: A command is accepted only while `busy`=0. Commands offered while busy are ignored. Each accepted command produces exactly one one-cycle `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | 0 start, 1 write, 2 read, 3 stop |
| cmd_wdata | input | DATA_W | Byte to write |
| cmd_lsb_first | input | 1 | Write bit order: 1 LSB-first |
| cmd_last | input | 1 | Read: final byte, answer not-acknowledge |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | DATA_W | Byte received by the last read |
| rsp_status | output | 8 | 8'h01 if a write was not acknowledged |
| scl_o | output | 1 | SCL pad value, fixed 0 |
| scl_oe | output | 1 | SCL pull-down enable |
| sda_i | input | 1 | SDA line level |
| sda_o | output | 1 | SDA pad value, fixed 0 |
| sda_oe | output | 1 | SDA pull-down enable |

## Verification
A wrong quarter or bit index shows at the lines within one quarter period. It appears as an SDA edge while SCL is high, which an observer decodes as a spurious start or stop, or as an SCL high time other than two quarters. A slip in the shift register appears one byte later as a mis-ordered bit pattern on the wire, or as a wrong `rsp_data`. A bad acknowledge-slot decision appears as a wrong `rsp_status` or a wrong ninth-clock SDA level. A fault in the handshake shows as a missing or repeated `done`, or as a stop taking effect in the middle of a byte.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_BYTE  = 2'd2,
    PH_STOP  = 2'd3
  } phase_e;

  localparam logic [1:0] QTR_FIRST = 2'd0;
  localparam logic [1:0] QTR_SAMPLE = 2'd1;
  localparam logic [1:0] QTR_LAST = 2'd3;

endpackage

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
  parameter int QUARTER_CLKS = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (QUARTER_CLKS > 2) ? $clog2(QUARTER_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUARTER_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = run;
  assign tick   = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!cnt_en) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // quarter ticks never come back to back when a quarter spans two or more clocks
  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/i2c_shift.sv
module i2c_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_lsb_first,
  input  logic              shift_en,
  input  logic              rx_sample,
  input  logic              ack_sample,
  input  logic              line_in,
  output logic              tx_bit,
  output logic [DATA_W-1:0] rx_data,
  output logic              nack
);
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic [DATA_W-1:0] tx_up, tx_down;
  logic              lsb_q, lsb_d;
  logic              nack_q, nack_d;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_bit
      if (gi == 0) begin : g_lo
        assign tx_up[gi] = 1'b0;
      end else begin : g_lo_n
        assign tx_up[gi] = tx_q[gi-1];
      end
      if (gi == DATA_W - 1) begin : g_hi
        assign tx_down[gi] = 1'b0;
      end else begin : g_hi_n
        assign tx_down[gi] = tx_q[gi+1];
      end
    end
  endgenerate

  assign tx_bit  = lsb_q ? tx_q[0] : tx_q[DATA_W-1];
  assign rx_data = rx_q;
  assign nack    = nack_q;

  always_comb begin
    tx_d   = tx_q;
    lsb_d  = lsb_q;
    rx_d   = rx_q;
    nack_d = nack_q;
    if (load) begin
      tx_d   = load_data;
      lsb_d  = load_lsb_first;
      nack_d = 1'b0;
    end else begin
      if (shift_en) begin
        tx_d = lsb_q ? tx_down : tx_up;
      end
      if (rx_sample) begin
        rx_d = {rx_q[DATA_W-2:0], line_in};
      end
      if (ack_sample) begin
        nack_d = line_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      lsb_q  <= 1'b0;
      rx_q   <= '0;
      nack_q <= 1'b0;
    end else begin
      tx_q   <= tx_d;
      lsb_q  <= lsb_d;
      rx_q   <= rx_d;
      nack_q <= nack_d;
    end
  end

  // the transmit register moves only at a bit boundary, never while loading
  assert_tx_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(shift_en) && !$past(load)) |-> $stable(tx_q));

endmodule

// File: rtl/i2c_seq.sv
module i2c_seq
  import i2c_eng_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_last,
  input  logic       tick,
  input  logic       tx_bit,
  output logic       busy,
  output logic       done,
  output logic       run,
  output logic       load,
  output logic       shift_en,
  output logic       rx_sample,
  output logic       ack_sample,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int BCW = $clog2(DATA_W + 1);
  localparam logic [BCW-1:0] ACK_SLOT = BCW'(DATA_W);

  phase_e         phase_q, phase_d;
  op_e            op_q, op_d;
  logic [1:0]     qtr_q, qtr_d;
  logic [BCW-1:0] bit_q, bit_d;
  logic           last_q, last_d;
  logic           hold_scl_q, hold_scl_d;
  logic           hold_sda_q, hold_sda_d;
  logic           done_q, done_d;
  logic           accept, data_slot, final_qtr;
  logic           drv_scl, drv_sda;

  assign accept    = cmd_valid && (phase_q == PH_IDLE);
  assign data_slot = bit_q < ACK_SLOT;
  assign final_qtr = (qtr_q == QTR_LAST) && ((phase_q != PH_BYTE) || !data_slot);

  // line drive for the current quarter (1 = pull low)
  always_comb begin
    drv_scl = hold_scl_q;
    drv_sda = hold_sda_q;
    case (phase_q)
      PH_IDLE: begin
        drv_scl = hold_scl_q;
        drv_sda = hold_sda_q;
      end
      PH_START: begin
        drv_scl = (qtr_q == QTR_FIRST) ? hold_scl_q : (qtr_q == QTR_LAST);
        drv_sda = qtr_q[1];
      end
      PH_BYTE: begin
        drv_scl = (qtr_q == QTR_FIRST) || (qtr_q == QTR_LAST);
        if (data_slot) begin
          drv_sda = (op_q == OP_WRITE) ? !tx_bit : 1'b0;
        end else begin
          drv_sda = (op_q == OP_READ) ? !last_q : 1'b0;
        end
      end
      PH_STOP: begin
        drv_scl = (qtr_q == QTR_FIRST);
        drv_sda = !qtr_q[1];
      end
      default: begin
        drv_scl = hold_scl_q;
        drv_sda = hold_sda_q;
      end
    endcase
  end

  always_comb begin
    phase_d    = phase_q;
    op_d       = op_q;
    qtr_d      = qtr_q;
    bit_d      = bit_q;
    last_d     = last_q;
    hold_scl_d = hold_scl_q;
    hold_sda_d = hold_sda_q;
    done_d     = 1'b0;
    if (accept) begin
      op_d   = op_e'(cmd_op);
      last_d = cmd_last;
      qtr_d  = QTR_FIRST;
      bit_d  = '0;
      case (op_e'(cmd_op))
        OP_START: phase_d = PH_START;
        OP_WRITE: phase_d = PH_BYTE;
        OP_READ:  phase_d = PH_BYTE;
        default:  phase_d = PH_STOP;
      endcase
    end else if (tick) begin
      if (final_qtr) begin
        phase_d    = PH_IDLE;
        done_d     = 1'b1;
        hold_scl_d = drv_scl;
        hold_sda_d = drv_sda;
      end else begin
        qtr_d = qtr_q + 2'd1;
        if (qtr_q == QTR_LAST) begin
          bit_d = bit_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      op_q       <= OP_START;
      qtr_q      <= QTR_FIRST;
      bit_q      <= '0;
      last_q     <= 1'b0;
      hold_scl_q <= 1'b0;
      hold_sda_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      op_q       <= op_d;
      qtr_q      <= qtr_d;
      bit_q      <= bit_d;
      last_q     <= last_d;
      hold_scl_q <= hold_scl_d;
      hold_sda_q <= hold_sda_d;
      done_q     <= done_d;
    end
  end

  assign busy       = (phase_q != PH_IDLE);
  assign run        = busy;
  assign done       = done_q;
  assign load       = accept;
  assign shift_en   = tick && (phase_q == PH_BYTE) && (qtr_q == QTR_LAST) &&
                      data_slot && (op_q == OP_WRITE);
  assign rx_sample  = tick && (phase_q == PH_BYTE) && (qtr_q == QTR_SAMPLE) &&
                      data_slot && (op_q == OP_READ);
  assign ack_sample = tick && (phase_q == PH_BYTE) && (qtr_q == QTR_SAMPLE) &&
                      !data_slot && (op_q == OP_WRITE);
  assign scl_oe     = drv_scl;
  assign sda_oe     = drv_sda;

  assert_end_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && (op_q != OP_STOP)) |-> scl_oe);

  assert_sda_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_BYTE) && $past(phase_q == PH_BYTE) && !scl_oe && !$past(scl_oe))
      |-> $stable(sda_oe));

  assert_stop_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && (op_q == OP_STOP)) |-> (!scl_oe && !sda_oe));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_op_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(op_q));

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine #(
  parameter int QUARTER_CLKS = 25,
  parameter int DATA_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_lsb_first,
  input  logic              cmd_last,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rsp_data,
  output logic [7:0]        rsp_status,
  output logic              scl_o,
  output logic              scl_oe,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              sda_oe
);
  logic [1:0] rsync_q;
  logic       rst_int_n;
  logic       run, tick, load, shift_en, rx_sample, ack_sample, tx_bit, nack;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rsync_q[1];

  i2c_qtick #(.QUARTER_CLKS(QUARTER_CLKS)) qtick_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run   (run),
    .tick  (tick)
  );

  i2c_seq #(.DATA_W(DATA_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_last   (cmd_last),
    .tick       (tick),
    .tx_bit     (tx_bit),
    .busy       (busy),
    .done       (done),
    .run        (run),
    .load       (load),
    .shift_en   (shift_en),
    .rx_sample  (rx_sample),
    .ack_sample (ack_sample),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe)
  );

  i2c_shift #(.DATA_W(DATA_W)) shift_i (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .load           (load),
    .load_data      (cmd_wdata),
    .load_lsb_first (cmd_lsb_first),
    .shift_en       (shift_en),
    .rx_sample      (rx_sample),
    .ack_sample     (ack_sample),
    .line_in        (sda_i),
    .tx_bit         (tx_bit),
    .rx_data        (rsp_data),
    .nack           (nack)
  );

  assign rsp_status = {7'd0, nack};
  assign scl_o      = 1'b0;
  assign sda_o      = 1'b0;

endmodule

// File: tb/i2c_byte_engine_tb_top.sv
module i2c_byte_engine_tb_top;
  localparam int TB_Q = 3;

  typedef struct {
    int         op;
    logic [7:0] data;
    logic [7:0] status;
  } exp_t;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, cmd_valid, cmd_lsb_first, cmd_last;
  logic [1:0] cmd_op;
  logic [7:0] cmd_wdata;
  logic       busy, done, scl_o, scl_oe, sda_o, sda_oe;
  logic [7:0] rsp_data, rsp_status;
  logic       scl_line, sda_line, slave_pull;

  int         n_tests = 0, n_fail = 0, cyc = 0;
  int         fall_cnt = 0, cap_cnt = 0, high_cnt = 0, last_high = 0;
  int         gap_cnt = 0, last_gap = 0, start_seen = 0, stop_seen = 0;
  int         sda_hi_changes = 0, done_total = 0, slave_mode = 0;
  logic [7:0] slave_byte = 8'h00;
  logic       slave_ack = 1'b0, byte_active = 1'b0;
  logic       scl_prev = 1'b1, sda_prev = 1'b1;
  logic       cap [0:8];
  exp_t       exp_q[$];

  assign scl_line = scl_oe ? scl_o : 1'b1;
  assign sda_line = (sda_oe ? sda_o : 1'b1) & ~slave_pull;

  always_comb begin
    slave_pull = 1'b0;
    if (slave_mode == 1 && fall_cnt == 8) slave_pull = slave_ack;
    if (slave_mode == 2 && fall_cnt < 8) slave_pull = ~slave_byte[7 - fall_cnt];
  end

  i2c_byte_engine #(.QUARTER_CLKS(TB_Q), .DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .cmd_lsb_first(cmd_lsb_first), .cmd_last(cmd_last),
    .busy(busy), .done(done), .rsp_data(rsp_data), .rsp_status(rsp_status),
    .scl_o(scl_o), .scl_oe(scl_oe), .sda_i(sda_line), .sda_o(sda_o), .sda_oe(sda_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  function automatic logic [7:0] cap_byte();
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[7 - i] = cap[i];
    return b;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7 - i];
    return r;
  endfunction

  // monitor: line observer and scoreboard
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      gap_cnt++;
      if (scl_prev && !scl_line) begin
        fall_cnt++;
        last_high = high_cnt;
        high_cnt  = 0;
      end else if (!scl_prev && scl_line) begin
        if (cap_cnt < 9) cap[cap_cnt] = sda_line;
        cap_cnt++;
        last_gap = gap_cnt;
        gap_cnt  = 0;
        high_cnt = 1;
      end else if (scl_line) begin
        high_cnt++;
      end
      if (scl_prev && scl_line && sda_prev && !sda_line) start_seen++;
      if (scl_prev && scl_line && !sda_prev && sda_line) stop_seen++;
      if (byte_active && scl_prev && scl_line && (sda_prev != sda_line)) sda_hi_changes++;
      if (done) begin
        done_total++;
        if (exp_q.size() == 0) begin
          check("R11 done without command", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check("R8 rsp_status", {24'd0, rsp_status}, {24'd0, e.status});
          if (e.op == 2) check("R9 rsp_data", {24'd0, rsp_data}, {24'd0, e.data});
        end
      end
    end
    scl_prev = scl_line;
    sda_prev = sda_line;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      finish_run();
    end
  end

  // driver: pushes the expected result, then issues the command
  task automatic run_cmd(input int op, input logic [7:0] data, input logic lsb,
                         input logic last, input logic ack_en, input logic [7:0] rd,
                         input logic poke);
    exp_t e;
    int   w;
    @(negedge clk);
    slave_mode  = (op == 1) ? 1 : ((op == 2) ? 2 : 0);
    slave_byte  = rd;
    slave_ack   = ack_en;
    fall_cnt    = 0;
    cap_cnt     = 0;
    byte_active = (op == 1) || (op == 2);
    e.op     = op;
    e.data   = rd;
    e.status = (op == 1 && !ack_en) ? 8'h01 : 8'h00;
    exp_q.push_back(e);
    cmd_valid     = 1'b1;
    cmd_op        = op[1:0];
    cmd_wdata     = data;
    cmd_lsb_first = lsb;
    cmd_last      = last;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = 2'd3;
      repeat (2) @(negedge clk);
      cmd_valid = 1'b0;
    end
    w = 0;
    while (!done && w < 2000) begin
      @(negedge clk);
      w++;
    end
    @(negedge clk);
    byte_active = 1'b0;
    slave_mode  = 0;
  endtask

  initial begin
    int s0, d0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_wdata = 8'h00;
    cmd_lsb_first = 1'b0; cmd_last = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 scl_oe in reset", {31'd0, scl_oe}, 32'd0);
    check("R2 sda_oe in reset", {31'd0, sda_oe}, 32'd0);
    check("R2 busy/done in reset", {30'd0, busy, done}, 32'd0);
    check("R1 pad values", {30'd0, scl_o, sda_o}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R2 lines released after reset", {30'd0, scl_line, sda_line}, 32'd3);
    check("R2 busy after reset", {31'd0, busy}, 32'd0);

    s0 = start_seen;
    run_cmd(0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    check("R5 start condition", start_seen - s0, 32'd1);
    check("R4 SCL low after start", {31'd0, scl_line}, 32'd0);

    run_cmd(1, 8'hA5, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
    check("R7 MSB-first bits on wire", {24'd0, cap_byte()}, 32'hA5);
    check("R7 ninth clock acknowledged", {31'd0, cap[8]}, 32'd0);
    check("R3 SCL high time", last_high, 2 * TB_Q);
    check("R3 bit cell", last_gap, 4 * TB_Q);
    check("R4 SCL low after write", {31'd0, scl_line}, 32'd0);

    run_cmd(1, 8'h1B, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    check("R7 LSB-first bits on wire", {24'd0, cap_byte()}, {24'd0, rev8(8'h1B)});
    check("R8 ninth clock released on nack", {31'd0, cap[8]}, 32'd1);

    s0 = start_seen;
    run_cmd(0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    check("R5 repeated start", start_seen - s0, 32'd1);

    run_cmd(1, 8'hD2, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
    check("R7 second MSB-first byte", {24'd0, cap_byte()}, 32'hD2);

    run_cmd(2, 8'h00, 1'b0, 1'b0, 1'b0, 8'h96, 1'b0);
    check("R9 read bits on wire", {24'd0, cap_byte()}, 32'h96);
    check("R10 master ack when not last", {31'd0, cap[8]}, 32'd0);
    check("R4 SCL low after read", {31'd0, scl_line}, 32'd0);

    run_cmd(2, 8'h00, 1'b0, 1'b1, 1'b0, 8'h5A, 1'b0);
    check("R10 master nack on last", {31'd0, cap[8]}, 32'd1);

    d0 = done_total;
    s0 = stop_seen;
    run_cmd(1, 8'h81, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1);
    repeat (30) @(negedge clk);
    check("R11 single done despite busy command", done_total - d0, 32'd1);
    check("R11 stop while busy ignored", stop_seen - s0, 32'd0);
    check("R11 SCL still low, idle", {30'd0, scl_line, busy}, 32'd0);
    check("R11 byte intact", {24'd0, cap_byte()}, 32'h81);

    s0 = stop_seen;
    run_cmd(3, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    check("R6 stop condition", stop_seen - s0, 32'd1);
    check("R6 lines released after stop", {30'd0, scl_line, sda_line}, 32'd3);

    check("R4 no SDA change while SCL high", sda_hi_changes, 32'd0);
    check("R11 all commands completed", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule